// File: doc/BRIEF.md
# Tag-Checked Instruction Fetch Unit

This unit owns the instruction counter and the instruction register of a small word-addressed processor. Memory words carry a two-bit content tag beside their data. When the unit is running and gets a fetch request, it checks that the counter addresses a real word. It then reads the word and its tag through a synchronous fetch port. An instruction word is latched into the instruction register together with a format flag. Anything else is a fault: the instruction register is cleared, a fault code is recorded and the unit stops running.

Execution logic outside the unit starts a run by presenting an entry address on `start_i`. It redirects the counter for jumps and branches through `load_i`. It watches `done_o`, `fmt_b_o` and `ir_o` to decide what to execute. Every successful fetch is charged a fixed memory cost on a running cycle total.

Top module: `ifetch_unit`

## Requirements
- R1: After reset the counter reads all ones (the value -1, an illegal address), the instruction register is 0, the cycle total is 0, `running_o` is low and `err_code_o` is 2'b00.
- R2: `start_i` while not running loads `entry_addr_i` into the counter, raises `running_o` and clears `err_code_o` to 2'b00; it is ignored while running.
- R3: A fetch of a word tagged 2'b10 (format A) loads the word into `ir_o`, drives `fmt_b_o` low and pulses `done_o` for exactly one cycle. The pulse comes in the third cycle after the request is sampled, and the counter then advances by 4.
- R4: A fetch of a word tagged 2'b11 (format B) behaves as in R3 but drives `fmt_b_o` high with the `done_o` pulse.
- R5: Each successful fetch adds 10 to `cycles_o`. A faulted fetch adds nothing.
- R6: If the counter is negative (top bit set) or its word index (counter shifted right by 2) is not below MEM_WORDS, the fetch issues no memory read. It clears `ir_o`, sets `err_code_o` to 2'b01, drops `running_o` and leaves the counter unchanged.
- R7: If the fetched word is tagged 2'b00 (undefined) or 2'b01 (data), the unit clears `ir_o`, sets `err_code_o` to 2'b10, drops `running_o`, gives no `done_o` pulse and leaves the counter unchanged.
- R8: While not running, `fetch_req_i` and `load_i` have no effect: there is no memory read, no `done_o` pulse and no change of the counter.
- R9: `load_i` while running replaces the counter with `load_addr_i`. If it falls in the cycle a fetch completes, the loaded value wins over the advance by 4. A `fetch_req_i` in the same idle cycle as `load_i` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a run at `entry_addr_i` |
| entry_addr_i | input | ADDR_W | Entry byte address |
| load_i | input | 1 | Replace the counter with `load_addr_i` |
| load_addr_i | input | ADDR_W | Jump target byte address |
| fetch_req_i | input | 1 | Request one instruction fetch |
| mem_rd_o | output | 1 | Fetch-port read strobe |
| mem_addr_o | output | clog2(MEM_WORDS) | Fetch-port word index |
| mem_rdata_i | input | DATA_W | Word returned one cycle after `mem_rd_o` |
| mem_tag_i | input | 2 | Content tag returned with the word |
| ic_o | output | ADDR_W | Instruction counter |
| ir_o | output | DATA_W | Instruction register |
| fmt_b_o | output | 1 | Format B flag, valid with `done_o` |
| done_o | output | 1 | One-cycle strobe for a successful fetch |
| running_o | output | 1 | Run state |
| err_code_o | output | 2 | 00 none, 01 address fault, 10 illegal instruction |
| cycles_o | output | CYC_W | Running cycle total |

## Verification
The counter has two writers that can act on the same clock edge. One is the advance by 4 at the end of a successful fetch. The other is a jump load from outside. The bench raises `load_i` so that it is sampled on exactly the edge where `done_o` rises. It then expects the instruction register to hold the fetched word and the counter to hold the jump target rather than the incremented address. A second overlap is `load_i` arriving together with `fetch_req_i` in an idle cycle. There the fetch must be dropped, so the bench counts memory reads.

// File: rtl/ifu_pkg.sv
package ifu_pkg;

  typedef enum logic [1:0] {
    TAG_UNDEF = 2'b00,
    TAG_DATA  = 2'b01,
    TAG_FMT_A = 2'b10,
    TAG_FMT_B = 2'b11
  } word_tag_e;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'b00,
    FLT_ADDR    = 2'b01,
    FLT_ILLEGAL = 2'b10
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_ISSUE = 2'b01,
    ST_RESP  = 2'b10
  } fetch_st_e;

endpackage

// File: rtl/ifu_range_chk.sv
module ifu_range_chk #(
  parameter int ADDR_W    = 16,
  parameter int MEM_WORDS = 64
) (
  input  logic [ADDR_W-1:0]            ic,
  output logic                         in_range,
  output logic [$clog2(MEM_WORDS)-1:0] word_idx
);
  localparam int IDX_W = $clog2(MEM_WORDS);
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(MEM_WORDS * 4);

  // Treated as unsigned, a negative counter exceeds LIMIT as long as the
  // memory spans less than half the address space.
  always_comb begin
    in_range = (ic < LIMIT);
    word_idx = ic[IDX_W+1:2];
  end
endmodule

// File: rtl/ifu_tag_decode.sv
module ifu_tag_decode
  import ifu_pkg::*;
(
  input  logic [1:0] tag,
  output logic       is_instr,
  output logic       is_fmt_b
);
  always_comb begin
    is_instr = (tag == TAG_FMT_A) || (tag == TAG_FMT_B);
    is_fmt_b = (tag == TAG_FMT_B);
  end
endmodule

// File: rtl/ifu_ctr.sv
module ifu_ctr #(
  parameter int ADDR_W = 16,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_en,
  input  logic [ADDR_W-1:0] entry,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              adv_en,
  output logic [ADDR_W-1:0] ic
);
  localparam logic [ADDR_W-1:0] INC = ADDR_W'(STEP);

  always_ff @(posedge clk) begin
    if (rst)           ic <= '1;
    else if (start_en) ic <= entry;
    else if (load_en)  ic <= load_val;
    else if (adv_en)   ic <= ic + INC;
  end
endmodule

// File: rtl/ifu_cycle_acc.sv
module ifu_cycle_acc #(
  parameter int CYC_W = 24,
  parameter int COST  = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             add_en,
  output logic [CYC_W-1:0] total
);
  localparam logic [CYC_W-1:0] STEP = CYC_W'(COST);

  always_ff @(posedge clk) begin
    if (rst)         total <= '0;
    else if (add_en) total <= total + STEP;
  end
endmodule

// File: rtl/ifetch_unit.sv
module ifetch_unit
  import ifu_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int MEM_WORDS  = 64,
  parameter int CYC_W      = 24,
  parameter int FETCH_COST = 10,
  parameter int STEP       = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start_i,
  input  logic [ADDR_W-1:0]            entry_addr_i,
  input  logic                         load_i,
  input  logic [ADDR_W-1:0]            load_addr_i,
  input  logic                         fetch_req_i,
  output logic                         mem_rd_o,
  output logic [$clog2(MEM_WORDS)-1:0] mem_addr_o,
  input  logic [DATA_W-1:0]            mem_rdata_i,
  input  logic [1:0]                   mem_tag_i,
  output logic [ADDR_W-1:0]            ic_o,
  output logic [DATA_W-1:0]            ir_o,
  output logic                         fmt_b_o,
  output logic                         done_o,
  output logic                         running_o,
  output logic [1:0]                   err_code_o,
  output logic [CYC_W-1:0]             cycles_o
);
  localparam int IDX_W = $clog2(MEM_WORDS);

  fetch_st_e        state;
  fault_e           fault_q;
  logic             in_range, is_instr, is_fmt_b;
  logic [IDX_W-1:0] word_idx;
  logic             start_ok, load_ok, fetch_ok, advance;

  always_comb begin
    start_ok = start_i && !running_o && (state == ST_IDLE);
    load_ok  = load_i && running_o;
    fetch_ok = fetch_req_i && running_o && !load_i && (state == ST_IDLE);
    advance  = (state == ST_RESP) && is_instr;
  end

  ifu_range_chk #(.ADDR_W(ADDR_W), .MEM_WORDS(MEM_WORDS)) u_range (
    .ic(ic_o), .in_range(in_range), .word_idx(word_idx)
  );

  ifu_tag_decode u_tag (
    .tag(mem_tag_i), .is_instr(is_instr), .is_fmt_b(is_fmt_b)
  );

  ifu_ctr #(.ADDR_W(ADDR_W), .STEP(STEP)) u_ctr (
    .clk(clk), .rst(rst),
    .start_en(start_ok), .entry(entry_addr_i),
    .load_en(load_ok), .load_val(load_addr_i),
    .adv_en(advance), .ic(ic_o)
  );

  ifu_cycle_acc #(.CYC_W(CYC_W), .COST(FETCH_COST)) u_cyc (
    .clk(clk), .rst(rst), .add_en(advance), .total(cycles_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      fault_q    <= FLT_NONE;
      ir_o       <= '0;
      fmt_b_o    <= 1'b0;
      done_o     <= 1'b0;
      running_o  <= 1'b0;
      mem_rd_o   <= 1'b0;
      mem_addr_o <= '0;
    end else begin
      done_o   <= 1'b0;
      mem_rd_o <= 1'b0;
      if (start_ok) begin
        running_o <= 1'b1;
        fault_q   <= FLT_NONE;
      end
      unique case (state)
        ST_IDLE: begin
          if (fetch_ok) begin
            if (in_range) begin
              mem_rd_o   <= 1'b1;
              mem_addr_o <= word_idx;
              state      <= ST_ISSUE;
            end else begin
              ir_o      <= '0;
              running_o <= 1'b0;
              fault_q   <= FLT_ADDR;
            end
          end
        end
        ST_ISSUE: state <= ST_RESP;
        ST_RESP: begin
          state <= ST_IDLE;
          if (is_instr) begin
            ir_o    <= mem_rdata_i;
            fmt_b_o <= is_fmt_b;
            done_o  <= 1'b1;
          end else begin
            ir_o      <= '0;
            running_o <= 1'b0;
            fault_q   <= FLT_ILLEGAL;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign err_code_o = fault_q;

  // R3: a successful fetch is signalled by a single-cycle pulse
  a_r3_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R5: each completed fetch charges the fixed cost exactly once
  a_r5_cycle_charge: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (cycles_o == $past(cycles_o) + CYC_W'(FETCH_COST)));

  // R6/R7: entering a fault leaves a cleared IR and a stopped unit
  a_r7_fault_stops: assert property (@(posedge clk) disable iff (rst)
    ((err_code_o != 2'b00) && ($past(err_code_o) == 2'b00)) |->
      ((ir_o == '0) && !running_o));

  // R8: the fetch port is only used by a running unit
  a_r8_read_needs_run: assert property (@(posedge clk) disable iff (rst)
    mem_rd_o |-> $past(running_o));

  // R9: without a coincident jump, completion advances the counter
  a_r9_advance: assert property (@(posedge clk) disable iff (rst)
    (done_o && !$past(load_i)) |-> (ic_o == $past(ic_o) + ADDR_W'(STEP)));

endmodule

// File: tb/tb_ifetch_unit.sv
module tb_ifetch_unit;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int MW = 64;
  localparam int CW = 24;

  logic          clk = 1'b0;
  logic          rst;
  logic          start_i, load_i, fetch_req_i;
  logic [AW-1:0] entry_addr_i, load_addr_i;
  logic          mem_rd_o;
  logic [5:0]    mem_addr_o;
  logic [DW-1:0] mem_rdata_i;
  logic [1:0]    mem_tag_i;
  logic [AW-1:0] ic_o;
  logic [DW-1:0] ir_o;
  logic          fmt_b_o, done_o, running_o;
  logic [1:0]    err_code_o;
  logic [CW-1:0] cycles_o;

  int checks = 0;
  int fails  = 0;
  int reads  = 0;
  bit ended  = 0;

  always #10 clk = ~clk;   // 50 MHz

  ifetch_unit dut (
    .clk(clk), .rst(rst), .start_i(start_i), .entry_addr_i(entry_addr_i),
    .load_i(load_i), .load_addr_i(load_addr_i), .fetch_req_i(fetch_req_i),
    .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i),
    .mem_tag_i(mem_tag_i), .ic_o(ic_o), .ir_o(ir_o), .fmt_b_o(fmt_b_o),
    .done_o(done_o), .running_o(running_o), .err_code_o(err_code_o),
    .cycles_o(cycles_o)
  );

  function automatic logic [DW-1:0] word_of(int i);
    return (DW'(i + 1) * 32'h0102_0305) ^ 32'h5A00_0000;
  endfunction

  function automatic logic [1:0] tag_of(int i);
    return 2'(i % 4);
  endfunction

  // tagged memory model: synchronous read, one cycle latency
  always @(posedge clk) begin
    if (mem_rd_o) begin
      mem_rdata_i <= word_of(int'(mem_addr_o));
      mem_tag_i   <= tag_of(int'(mem_addr_o));
      reads       <= reads + 1;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start(input logic [AW-1:0] a);
    @(negedge clk); start_i = 1'b1; entry_addr_i = a;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic do_load(input logic [AW-1:0] a);
    @(negedge clk); load_i = 1'b1; load_addr_i = a;
    @(negedge clk); load_i = 1'b0;
  endtask

  task automatic do_fetch();
    @(negedge clk); fetch_req_i = 1'b1;
    @(negedge clk); fetch_req_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int ok_fetches;
    int r0;
    logic run_m;
    ok_fetches = 0;
    rst = 1'b1; start_i = 0; load_i = 0; fetch_req_i = 0;
    entry_addr_i = '0; load_addr_i = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ic", 64'(ic_o), 64'hFFFF);
    chk("R1 ir", 64'(ir_o), 64'h0);
    chk("R1 running", 64'(running_o), 64'h0);
    chk("R1 cycles", 64'(cycles_o), 64'h0);
    chk("R1 err", 64'(err_code_o), 64'h0);

    // R8 ignored while stopped
    r0 = reads;
    do_load(16'h0010);
    do_fetch();
    chk("R8 ic unchanged", 64'(ic_o), 64'hFFFF);
    chk("R8 no read", 64'(reads), 64'(r0));
    chk("R8 no done", 64'(done_o), 64'h0);

    // sweep every word of the memory
    run_m = 1'b0;
    for (int i = 0; i < MW; i++) begin
      if (!run_m) begin
        do_start(AW'(4 * i));
        chk("R2 running", 64'(running_o), 64'h1);
        chk("R2 err cleared", 64'(err_code_o), 64'h0);
        chk("R2 entry", 64'(ic_o), 64'(4 * i));
      end else begin
        do_load(AW'(4 * i));
        chk("R9 load", 64'(ic_o), 64'(4 * i));
      end
      r0 = reads;
      do_fetch();
      chk("R3 one read", 64'(reads), 64'(r0 + 1));
      if (tag_of(i) >= 2'b10) begin
        ok_fetches++;
        chk(tag_of(i) == 2'b11 ? "R4 done" : "R3 done", 64'(done_o), 64'h1);
        chk(tag_of(i) == 2'b11 ? "R4 ir" : "R3 ir", 64'(ir_o), 64'(word_of(i)));
        chk(tag_of(i) == 2'b11 ? "R4 fmt" : "R3 fmt", 64'(fmt_b_o),
            64'(tag_of(i) == 2'b11));
        chk("R3 ic advance", 64'(ic_o), 64'(4 * i + 4));
        chk("R5 cycles", 64'(cycles_o), 64'(10 * ok_fetches));
        @(negedge clk);
        chk("R3 pulse width", 64'(done_o), 64'h0);
        run_m = 1'b1;
      end else begin
        chk("R7 no done", 64'(done_o), 64'h0);
        chk("R7 ir cleared", 64'(ir_o), 64'h0);
        chk("R7 stopped", 64'(running_o), 64'h0);
        chk("R7 err code", 64'(err_code_o), 64'h2);
        chk("R7 ic held", 64'(ic_o), 64'(4 * i));
        chk("R5 no charge", 64'(cycles_o), 64'(10 * ok_fetches));
        run_m = 1'b0;
      end
    end

    // R6 just past the end of memory (unit is running after word 63)
    do_load(AW'(4 * MW));
    r0 = reads;
    do_fetch();
    chk("R6 no read", 64'(reads), 64'(r0));
    chk("R6 err code", 64'(err_code_o), 64'h1);
    chk("R6 stopped", 64'(running_o), 64'h0);
    chk("R6 ir cleared", 64'(ir_o), 64'h0);
    chk("R6 ic held", 64'(ic_o), 64'(4 * MW));

    // R6 negative counter
    do_start(16'hFFFC);
    do_fetch();
    chk("R6 negative err", 64'(err_code_o), 64'h1);
    chk("R6 negative ic", 64'(ic_o), 64'hFFFC);

    // R9 jump lands on the edge where the fetch completes
    do_start(16'h0008);
    @(negedge clk); fetch_req_i = 1'b1;
    @(negedge clk); fetch_req_i = 1'b0;
    @(negedge clk); load_i = 1'b1; load_addr_i = 16'h0040;
    @(negedge clk); load_i = 1'b0;
    ok_fetches++;
    chk("R9 coincident done", 64'(done_o), 64'h1);
    chk("R9 coincident ir", 64'(ir_o), 64'(word_of(2)));
    chk("R9 load wins", 64'(ic_o), 64'h0040);
    chk("R5 cycles total", 64'(cycles_o), 64'(10 * ok_fetches));

    // R9 load and fetch request in the same idle cycle: fetch dropped
    r0 = reads;
    @(negedge clk); load_i = 1'b1; load_addr_i = 16'h000C; fetch_req_i = 1'b1;
    @(negedge clk); load_i = 1'b0; fetch_req_i = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R9 fetch dropped", 64'(reads), 64'(r0));
    chk("R9 ic loaded", 64'(ic_o), 64'h000C);

    // R2 start ignored while running
    do_start(16'h0020);
    chk("R2 start ignored", 64'(ic_o), 64'h000C);

    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule